// File: doc/BRIEF.md
# Test Access Port State Machine

This block is the sixteen-state controller behind a boundary-scan test port. It runs on the test clock `tck` and is steered only by the mode-select input `tms`, sampled on each rising edge. An active-low asynchronous reset `trst_n` can force it straight to its reset state. A parameter can remove this reset, in which case holding `tms` high is the only way back to reset.

From its current state the controller produces decoded control strobes for the instruction register and the test data registers: capture, shift and update for each, a reset indication, and a select that steers the serial output path to the instruction register. It also produces an output enable for the serial data pin, registered on the falling edge of `tck`, so that the pin driver switches half a cycle after the state changes.

The registers, the instruction decoding and any chaining of several devices on a board are left to neighbouring logic.

Top module: `tap_fsm_ctrl`

## Requirements
- R1: While `trst_n` is low the controller is forced, without waiting for a clock edge, into Test-Logic-Reset (`state_o` = 0), `tlr_o` is high and `tdo_en_o` is low.
- R2: On each rising edge of `tck` the state moves according to `tms`. The state codes on `state_o` are: 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. The arcs, written as (tms=0, tms=1), are:
  - 0:(1,0), 1:(1,2), 2:(3,9), 3:(4,5), 4:(4,5), 5:(6,8), 6:(6,7), 7:(4,8), 8:(1,2)
  - 9:(10,0), 10:(11,12), 11:(11,12), 12:(13,15), 13:(13,14), 14:(11,15), 15:(1,2)
- R3: After five consecutive rising edges with `tms` high, the controller is in Test-Logic-Reset, whatever state it started from.
- R4: In Shift-DR, Shift-IR, Pause-DR and Pause-IR, `tms` low keeps the controller in the same state.
- R5: From Exit1 or Exit2 of either branch, `tms` high moves to the Update state of that branch.
- R6: Each of `cap_ir_o`, `shf_ir_o`, `upd_ir_o`, `cap_dr_o`, `shf_dr_o`, `upd_dr_o` and `tlr_o` is high exactly while the state is its matching state. `sel_ir_o` is high exactly in states 9 to 15.
- R7: `tdo_en_o` changes only on a falling edge of `tck`. After each falling edge it is high exactly when the state is Shift-DR or Shift-IR.
- R8: While `tck` is held low, the state and all outputs keep their values, whatever `tms` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| state_o | output | 4 | Current state code |
| tlr_o | output | 1 | In Test-Logic-Reset |
| sel_ir_o | output | 1 | Instruction branch selected |
| cap_ir_o | output | 1 | Capture-IR strobe |
| shf_ir_o | output | 1 | Shift-IR strobe |
| upd_ir_o | output | 1 | Update-IR strobe |
| cap_dr_o | output | 1 | Capture-DR strobe |
| shf_dr_o | output | 1 | Shift-DR strobe |
| upd_dr_o | output | 1 | Update-DR strobe |
| tdo_en_o | output | 1 | Serial output enable, falling-edge registered |

## Verification
The bench drives random `tms` from a fixed seed and keeps going until all 32 state/mode arcs have been taken, comparing each step with its own next-state table. A design with a single crossed arc, for example Exit2 returning to Pause, or Select-IR falling through to Run-Test/Idle, would show a wrong state code on the next cycle. Directed cases cover the following:
- reset asserted between clock edges, which catches a reset that waits for a clock edge;
- runs of five ones from deep states, which catch a path that needs six;
- a stopped clock with `tms` toggling, which catches logic that is not edge-driven;
- the output enable checked half a cycle apart, which catches an enable registered on the wrong edge and switching a half cycle early.

// File: rtl/tap_pkg.sv
// Package: shared state codes for the test access port controller.
// Assumes a four-bit binary state code that neighbouring logic may observe.
package tap_pkg;
    localparam int STW = 4;

    typedef enum logic [STW-1:0] {
        ST_TLR   = 4'd0,
        ST_IDLE  = 4'd1,
        ST_SELDR = 4'd2,
        ST_CAPDR = 4'd3,
        ST_SHDR  = 4'd4,
        ST_EX1DR = 4'd5,
        ST_PSDR  = 4'd6,
        ST_EX2DR = 4'd7,
        ST_UPDR  = 4'd8,
        ST_SELIR = 4'd9,
        ST_CAPIR = 4'd10,
        ST_SHIR  = 4'd11,
        ST_EX1IR = 4'd12,
        ST_PSIR  = 4'd13,
        ST_EX2IR = 4'd14,
        ST_UPIR  = 4'd15
    } tap_state_e;
endpackage

// File: rtl/tap_next_state.sv
// Module: pure next-state logic of the sixteen-state scan controller.
// Assumes the mode input is stable around the rising clock edge.
module tap_next_state
    import tap_pkg::*;
(
    input  tap_state_e cur_i,
    input  logic       tms_i,
    output tap_state_e nxt_o
);
    // Chooses the successor state for each current state and mode bit.
    always_comb begin
        unique case (cur_i)
            ST_TLR:   nxt_o = tms_i ? ST_TLR   : ST_IDLE;
            ST_IDLE:  nxt_o = tms_i ? ST_SELDR : ST_IDLE;
            ST_SELDR: nxt_o = tms_i ? ST_SELIR : ST_CAPDR;
            ST_CAPDR: nxt_o = tms_i ? ST_EX1DR : ST_SHDR;
            ST_SHDR:  nxt_o = tms_i ? ST_EX1DR : ST_SHDR;
            ST_EX1DR: nxt_o = tms_i ? ST_UPDR  : ST_PSDR;
            ST_PSDR:  nxt_o = tms_i ? ST_EX2DR : ST_PSDR;
            ST_EX2DR: nxt_o = tms_i ? ST_UPDR  : ST_SHDR;
            ST_UPDR:  nxt_o = tms_i ? ST_SELDR : ST_IDLE;
            ST_SELIR: nxt_o = tms_i ? ST_TLR   : ST_CAPIR;
            ST_CAPIR: nxt_o = tms_i ? ST_EX1IR : ST_SHIR;
            ST_SHIR:  nxt_o = tms_i ? ST_EX1IR : ST_SHIR;
            ST_EX1IR: nxt_o = tms_i ? ST_UPIR  : ST_PSIR;
            ST_PSIR:  nxt_o = tms_i ? ST_EX2IR : ST_PSIR;
            ST_EX2IR: nxt_o = tms_i ? ST_UPIR  : ST_SHIR;
            ST_UPIR:  nxt_o = tms_i ? ST_SELDR : ST_IDLE;
            default:  nxt_o = ST_TLR;
        endcase
    end
endmodule

// File: rtl/tap_state_reg.sv
// Module: rising-edge state register with asynchronous active-low clear.
// Assumes the clock may stop low indefinitely; the register simply holds.
module tap_state_reg
    import tap_pkg::*;
(
    input  logic       tck_i,
    input  logic       rst_n_i,
    input  tap_state_e nxt_i,
    output tap_state_e cur_o
);
    // Stores the controller state; reset wins at once.
    always_ff @(posedge tck_i or negedge rst_n_i) begin
        if (!rst_n_i) cur_o <= ST_TLR;
        else          cur_o <= nxt_i;
    end
endmodule

// File: rtl/tap_out_decode.sv
// Module: decodes control strobes from the state and registers the serial
// output enable on the falling clock edge.
// Assumes the state only changes on rising edges or on reset.
module tap_out_decode
    import tap_pkg::*;
(
    input  logic       tck_i,
    input  logic       rst_n_i,
    input  tap_state_e cur_i,
    output logic       tlr_o,
    output logic       sel_ir_o,
    output logic       cap_ir_o,
    output logic       shf_ir_o,
    output logic       upd_ir_o,
    output logic       cap_dr_o,
    output logic       shf_dr_o,
    output logic       upd_dr_o,
    output logic       tdo_en_o
);
    logic shifting;

    // Level strobes follow the current state directly.
    always_comb begin
        tlr_o    = (cur_i == ST_TLR);
        cap_ir_o = (cur_i == ST_CAPIR);
        shf_ir_o = (cur_i == ST_SHIR);
        upd_ir_o = (cur_i == ST_UPIR);
        cap_dr_o = (cur_i == ST_CAPDR);
        shf_dr_o = (cur_i == ST_SHDR);
        upd_dr_o = (cur_i == ST_UPDR);
        sel_ir_o = (cur_i >= ST_SELIR);
        shifting = (cur_i == ST_SHDR) || (cur_i == ST_SHIR);
    end

    // Output enable moves half a cycle after the state, on the falling edge.
    always_ff @(negedge tck_i or negedge rst_n_i) begin
        if (!rst_n_i) tdo_en_o <= 1'b0;
        else          tdo_en_o <= shifting;
    end
endmodule

// File: rtl/tap_fsm_ctrl.sv
// Module: top of the test access port controller.
// Assumes tms is driven away from the rising edge of tck. HAS_TRST=0
// removes the reset pin's effect, leaving five ones on tms as the only way back to reset.
module tap_fsm_ctrl
    import tap_pkg::*;
#(
    parameter bit HAS_TRST = 1'b1
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           tms,
    output logic [STW-1:0] state_o,
    output logic           tlr_o,
    output logic           sel_ir_o,
    output logic           cap_ir_o,
    output logic           shf_ir_o,
    output logic           upd_ir_o,
    output logic           cap_dr_o,
    output logic           shf_dr_o,
    output logic           upd_dr_o,
    output logic           tdo_en_o
);
    tap_state_e cur_st;
    tap_state_e nxt_st;
    logic       rst_n;

    // Selects whether the reset pin is honoured.
    generate
        if (HAS_TRST) begin : g_trst
            assign rst_n = trst_n;
        end else begin : g_no_trst
            assign rst_n = 1'b1;
        end
    endgenerate

    tap_next_state u_next (
        .cur_i (cur_st),
        .tms_i (tms),
        .nxt_o (nxt_st)
    );

    tap_state_reg u_sreg (
        .tck_i   (tck),
        .rst_n_i (rst_n),
        .nxt_i   (nxt_st),
        .cur_o   (cur_st)
    );

    tap_out_decode u_dec (
        .tck_i    (tck),
        .rst_n_i  (rst_n),
        .cur_i    (cur_st),
        .tlr_o    (tlr_o),
        .sel_ir_o (sel_ir_o),
        .cap_ir_o (cap_ir_o),
        .shf_ir_o (shf_ir_o),
        .upd_ir_o (upd_ir_o),
        .cap_dr_o (cap_dr_o),
        .shf_dr_o (shf_dr_o),
        .upd_dr_o (upd_dr_o),
        .tdo_en_o (tdo_en_o)
    );

    // Exposes the state code at the port.
    assign state_o = cur_st;
endmodule

// File: rtl/tap_fsm_ctrl_chk.sv
// Module: property checker for tap_fsm_ctrl, bound to every instance.
// Assumes the default build with the reset pin honoured.
module tap_fsm_ctrl_chk (
    input logic       tck,
    input logic       trst_n,
    input logic       tms,
    input logic [3:0] state_o,
    input logic       tlr_o,
    input logic       sel_ir_o,
    input logic       cap_ir_o,
    input logic       shf_ir_o,
    input logic       upd_ir_o,
    input logic       cap_dr_o,
    input logic       shf_dr_o,
    input logic       upd_dr_o,
    input logic       tdo_en_o
);
    logic [2:0] ones_q;

    // Counts consecutive high mode samples, saturating at 5.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)            ones_q <= 3'd0;
        else if (!tms)          ones_q <= 3'd0;
        else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
    end

    // Reset pin holds the reset state, sampled mid-cycle.
    always @(negedge tck) begin
        if (!trst_n) begin
            AST_TRST_FORCE: assert (state_o == 4'd0 && tlr_o && !tdo_en_o) else $error("reset not forced"); // R1
        end
    end

    AST_FIVE_ONES: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q >= 3'd4 && tms) |=> (state_o == 4'd0)) else $error("five ones"); // R3
    AST_SHIFT_DR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (state_o == 4'd4 && !tms) |=> (state_o == 4'd4)) else $error("shift dr"); // R4
    AST_PAUSE_IR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (state_o == 4'd13 && !tms) |=> (state_o == 4'd13)) else $error("pause ir"); // R4
    AST_EXIT_DR_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        ((state_o == 4'd5 || state_o == 4'd7) && tms) |=> (state_o == 4'd8)) else $error("exit dr"); // R5
    AST_EXIT_IR_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        ((state_o == 4'd12 || state_o == 4'd14) && tms) |=> (state_o == 4'd15)) else $error("exit ir"); // R5
    AST_STROBE_ONEHOT: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({tlr_o, cap_ir_o, shf_ir_o, upd_ir_o, cap_dr_o, shf_dr_o, upd_dr_o})) else $error("strobes"); // R6
    AST_SEL_IR_BRANCH: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_ir_o || shf_ir_o || upd_ir_o) |-> sel_ir_o) else $error("sel ir"); // R6
    AST_TDO_EN_PHASE: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en_o == (state_o == 4'd4 || state_o == 4'd11)) else $error("tdo en"); // R7
endmodule

bind tap_fsm_ctrl tap_fsm_ctrl_chk u_chk (.*);

// File: tb/tap_fsm_ctrl_tb.sv
module tap_fsm_ctrl_tb;
    logic       tck = 1'b0;
    logic       clk_run = 1'b1;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic [3:0] state_o;
    logic       tlr_o, sel_ir_o, cap_ir_o, shf_ir_o, upd_ir_o;
    logic       cap_dr_o, shf_dr_o, upd_dr_o, tdo_en_o;

    int checks = 0;
    int fails  = 0;
    logic [3:0]  mdl = 4'd0;
    logic [31:0] seen = '0;

    tap_fsm_ctrl u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state_o(state_o),
        .tlr_o(tlr_o), .sel_ir_o(sel_ir_o), .cap_ir_o(cap_ir_o),
        .shf_ir_o(shf_ir_o), .upd_ir_o(upd_ir_o), .cap_dr_o(cap_dr_o),
        .shf_dr_o(shf_dr_o), .upd_dr_o(upd_dr_o), .tdo_en_o(tdo_en_o)
    );

    // 125 MHz test clock that can be parked low.
    always #4 if (clk_run || tck) tck = ~tck;

    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic b);
        case (s)
            4'd0:  return b ? 4'd0  : 4'd1;
            4'd1:  return b ? 4'd2  : 4'd1;
            4'd2:  return b ? 4'd9  : 4'd3;
            4'd3:  return b ? 4'd5  : 4'd4;
            4'd4:  return b ? 4'd5  : 4'd4;
            4'd5:  return b ? 4'd8  : 4'd6;
            4'd6:  return b ? 4'd7  : 4'd6;
            4'd7:  return b ? 4'd8  : 4'd4;
            4'd8:  return b ? 4'd2  : 4'd1;
            4'd9:  return b ? 4'd0  : 4'd10;
            4'd10: return b ? 4'd12 : 4'd11;
            4'd11: return b ? 4'd12 : 4'd11;
            4'd12: return b ? 4'd15 : 4'd13;
            4'd13: return b ? 4'd14 : 4'd13;
            4'd14: return b ? 4'd15 : 4'd11;
            default: return b ? 4'd2 : 4'd1;
        endcase
    endfunction

    function automatic logic [7:0] ref_strobes(input logic [3:0] s);
        // {tlr, sel_ir, cap_ir, shf_ir, upd_ir, cap_dr, shf_dr, upd_dr}
        return {s == 4'd0, s >= 4'd9, s == 4'd10, s == 4'd11, s == 4'd15,
                s == 4'd3, s == 4'd4, s == 4'd8};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, {28'd0, state_o}, {28'd0, mdl});
        chk("R6", {24'd0, tlr_o, sel_ir_o, cap_ir_o, shf_ir_o, upd_ir_o,
                   cap_dr_o, shf_dr_o, upd_dr_o}, {24'd0, ref_strobes(mdl)});
    endtask

    // One clock: check enable after the falling edge, drive, check after rising.
    task automatic step(input logic b, input string req);
        @(negedge tck); #1;
        chk("R7", {31'd0, tdo_en_o}, {31'd0, (mdl == 4'd4 || mdl == 4'd11)});
        tms = b;
        seen[{mdl, b}] = 1'b1;
        @(posedge tck); #1;
        mdl = ref_next(mdl, b);
        chk_state(req);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        // R1 reset state while held in reset
        repeat (3) @(posedge tck);
        #2;
        chk("R1", {28'd0, state_o}, 32'd0);
        chk("R1", {31'd0, tlr_o}, 32'd1);
        chk("R1", {31'd0, tdo_en_o}, 32'd0);
        @(negedge tck); #1 trst_n = 1'b1;
        mdl = 4'd0;

        // R2 directed path into Shift-DR and Shift-IR
        step(0, "R2"); step(1, "R2"); step(0, "R2"); step(0, "R4");
        step(0, "R4"); step(1, "R2"); step(1, "R5");
        step(1, "R2"); step(1, "R2"); step(0, "R2"); step(0, "R2");
        step(0, "R4"); step(1, "R2"); step(0, "R2"); step(0, "R4");
        step(1, "R2"); step(1, "R5"); step(0, "R2");

        // R2 random walk until every arc is taken
        for (int i = 0; i < 6000 && seen != 32'hFFFF_FFFF; i++)
            step(logic'($urandom % 2), "R2");
        chk("R2 arcs", seen, 32'hFFFF_FFFF);

        // R3 five ones from several deep states
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 3 + k * 2; j++) step(logic'($urandom % 2), "R2");
            for (int j = 0; j < 5; j++) step(1, "R3");
            chk("R3", {28'd0, state_o}, 32'd0);
        end

        // R8 park the clock low inside Shift-IR; tms toggling must not matter
        step(0, "R2"); step(1, "R2"); step(1, "R2"); step(0, "R2"); step(0, "R2");
        @(negedge tck); #1;
        clk_run = 1'b0;
        for (int j = 0; j < 10; j++) begin #7 tms = ~tms; end
        chk("R8", {28'd0, state_o}, {28'd0, mdl});
        chk("R8", {31'd0, tdo_en_o}, 32'd1);
        tms = 1'b0;
        clk_run = 1'b1;
        @(posedge tck); #1;
        mdl = ref_next(mdl, 1'b0);
        chk_state("R4");

        // R1 reset asserted between edges acts at once
        step(1, "R2");
        @(negedge tck); #2 trst_n = 1'b0;
        #1;
        chk("R1", {28'd0, state_o}, 32'd0);
        chk("R1", {31'd0, tdo_en_o}, 32'd0);
        mdl = 4'd0;
        @(negedge tck); #1 trst_n = 1'b1; tms = 1'b0;
        @(posedge tck); #1;
        mdl = ref_next(mdl, 1'b0);
        chk_state("R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule